// File: doc/BRIEF.md
# Charge-Balancing Sensor Loop Sequencer

This block is the digital controller for a temperature sensor front end. The front end is built around a second-order switched-capacitor delta-sigma loop. At the end of each loop cycle it samples the 1-bit comparator decision and uses it to choose the next integration:

- **Short cycle.** After a 1, the loop integrates the negated junction voltage for a single sample period.
- **Long cycle.** After a 0, it accumulates the scaled junction-voltage difference on one unit capacitor over `ALPHA` sample periods.

During a long cycle, a matching pointer steps through the `RATIO+1` bias current sources. `ALPHA` is a whole multiple of `RATIO+1`, so the rotation closes inside the cycle.

The sequencer runs at twice the sample rate, so every sample period has two ticks. The current-source positions are swapped in the second tick of each period. One measurement consists of two conversions of a programmable number of loop cycles each. The second conversion runs with inverted input polarity, which removes offset. The bitstream is polarity-corrected before it is passed to the decimator.

Top module: `tsdm_seq`

## Requirements
- R1: While busy, exactly one of `sel_vbe_o` and `sel_dvbe_o` is high. `sel_dvbe_o` is high when the bit sampled at the end of the previous cycle was 0, and in the first cycle of each conversion. `sel_vbe_o` is high when that bit was 1.
- R2: A short cycle lasts one sample period (2 ticks).
- R3: A long cycle lasts `ALPHA` sample periods (28 ticks at defaults).
- R4: During a long cycle, `dem_idx_o` is 0 in the first sample period and advances by 1 each period, modulo `RATIO+1` (7). Outside long cycles it is 0. Each source is used exactly `ALPHA/(RATIO+1)` times per long cycle.
- R5: While busy, `swap_o` is low in the first tick of each sample period and high in the second.
- R6: `bit_i` is sampled in the last tick of each cycle. One tick later, `bs_valid_o` pulses and `bs_bit_o` equals that bit XOR the polarity of the conversion that cycle belonged to.
- R7: `chop_o` is 0 for the first `conv_len_i` cycles and 1 for the next `conv_len_i` cycles. The first cycle of the second conversion is long.
- R8: `done_o` pulses for one tick together with the final `bs_valid_o`, and `busy_o` falls in that same tick.
- R9: `start_i` while busy is ignored. `conv_len_i` is captured only when a run is accepted.
- R10: A `conv_len_i` of 0 runs as a length of 1.
- R11: `rst_ni` low asynchronously clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, two ticks per sample period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a two-conversion measurement when idle |
| conv_len_i | input | LEN_W | Loop cycles per conversion |
| bit_i | input | 1 | Comparator decision |
| busy_o | output | 1 | Measurement in progress |
| chop_o | output | 1 | Input polarity of current conversion |
| swap_o | output | 1 | Current-source position swap (second half of period) |
| sel_vbe_o | output | 1 | Integrate negated junction voltage |
| sel_dvbe_o | output | 1 | Integrate scaled difference voltage |
| dem_idx_o | output | IDX_W | Selected unit current source |
| bs_valid_o | output | 1 | Bitstream strobe |
| bs_bit_o | output | 1 | Polarity-corrected bitstream bit |
| done_o | output | 1 | Measurement complete pulse |

## Verification
Two events can fall in the same tick:

- **Cycle end and matching wrap.** The end of a long cycle coincides with the matching pointer wrapping, and the pointer must return to 0 rather than advance. Stimulus patterns with runs of zeros put long cycles back to back, and the bench checks that `dem_idx_o` restarts at 0 in each one.
- **Conversion end and polarity flip.** The last cycle of the first conversion coincides with the polarity flip. Here the emitted bit must still carry the old polarity, while the next cycle must be long under the new one.

Patterns whose bit at that boundary is 1 provoke the second case. The bench judges it from the bitstream value and from the length of the following cycle.

// File: rtl/tsdm_pkg.sv
package tsdm_pkg;
  localparam int unsigned ALPHA_DEF = 14;
  localparam int unsigned RATIO_DEF = 6;
  localparam int unsigned LEN_W_DEF = 4;
endpackage

// File: rtl/tsdm_unit_timer.sv
module tsdm_unit_timer #(
  parameter int unsigned ALPHA = tsdm_pkg::ALPHA_DEF,
  localparam int unsigned CNT_W = $clog2(ALPHA)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_i,
  output logic phase_o,
  output logic end_unit_o,
  output logic end_cycle_o
);
  logic             phase_q;
  logic [CNT_W-1:0] unit_q;

  assign end_unit_o  = run_i & phase_q;
  assign end_cycle_o = end_unit_o & (~long_i | (unit_q == CNT_W'(ALPHA - 1)));
  assign phase_o     = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      unit_q  <= '0;
    end else if (!run_i) begin
      phase_q <= 1'b0;
      unit_q  <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (end_cycle_o)     unit_q <= '0;
      else if (end_unit_o) unit_q <= unit_q + 1'b1;
    end
  end
endmodule

// File: rtl/tsdm_dem_ptr.sv
module tsdm_dem_ptr #(
  parameter int unsigned NSRC = tsdm_pkg::RATIO_DEF + 1,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;
  assign idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (adv_i)  idx_q <= (idx_q == IDX_W'(NSRC - 1)) ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/tsdm_seq.sv
module tsdm_seq #(
  parameter int unsigned ALPHA = tsdm_pkg::ALPHA_DEF,
  parameter int unsigned RATIO = tsdm_pkg::RATIO_DEF,
  parameter int unsigned LEN_W = tsdm_pkg::LEN_W_DEF,
  localparam int unsigned NSRC  = RATIO + 1,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] conv_len_i,
  input  logic             bit_i,
  output logic             busy_o,
  output logic             chop_o,
  output logic             swap_o,
  output logic             sel_vbe_o,
  output logic             sel_dvbe_o,
  output logic [IDX_W-1:0] dem_idx_o,
  output logic             bs_valid_o,
  output logic             bs_bit_o,
  output logic             done_o
);
  logic             busy_q, chop_q, long_q, bsv_q, bsb_q, done_q;
  logic [LEN_W-1:0] len_q, cyc_q;
  logic             phase, end_unit, end_cycle, last_cyc, accept;
  logic [IDX_W-1:0] idx;

  tsdm_unit_timer #(.ALPHA(ALPHA)) u_timer (
    .clk_i, .rst_ni,
    .run_i      (busy_q),
    .long_i     (long_q),
    .phase_o    (phase),
    .end_unit_o (end_unit),
    .end_cycle_o(end_cycle)
  );

  tsdm_dem_ptr #(.NSRC(NSRC)) u_dem (
    .clk_i, .rst_ni,
    .clr_i (end_cycle | ~busy_q),
    .adv_i (end_unit & long_q),
    .idx_o (idx)
  );

  assign accept   = start_i & ~busy_q;
  assign last_cyc = (cyc_q == len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; chop_q <= 1'b0; long_q <= 1'b0;
      len_q  <= '0;   cyc_q  <= '0;
      bsv_q  <= 1'b0; bsb_q  <= 1'b0; done_q <= 1'b0;
    end else begin
      bsv_q  <= busy_q & end_cycle;
      done_q <= busy_q & end_cycle & last_cyc & chop_q;
      if (busy_q & end_cycle) bsb_q <= bit_i ^ chop_q;
      if (accept) begin
        busy_q <= 1'b1;
        chop_q <= 1'b0;
        long_q <= 1'b1;
        cyc_q  <= '0;
        len_q  <= (conv_len_i == '0) ? LEN_W'(1) : conv_len_i;
      end else if (busy_q & end_cycle) begin
        if (last_cyc) begin
          cyc_q  <= '0;
          long_q <= 1'b1;  // each conversion opens with a long cycle
          if (chop_q) busy_q <= 1'b0;
          else        chop_q <= 1'b1;
        end else begin
          cyc_q  <= cyc_q + 1'b1;
          long_q <= ~bit_i;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign chop_o     = busy_q & chop_q;
  assign swap_o     = busy_q & phase;
  assign sel_vbe_o  = busy_q & ~long_q;
  assign sel_dvbe_o = busy_q & long_q;
  assign dem_idx_o  = (busy_q & long_q) ? idx : '0;
  assign bs_valid_o = bsv_q;
  assign bs_bit_o   = bsb_q;
  assign done_o     = done_q;
endmodule

// File: rtl/tsdm_seq_chk.sv
module tsdm_seq_chk #(
  parameter int unsigned ALPHA = tsdm_pkg::ALPHA_DEF,
  parameter int unsigned RATIO = tsdm_pkg::RATIO_DEF,
  localparam int unsigned NSRC  = RATIO + 1,
  localparam int unsigned IDX_W = $clog2(NSRC),
  localparam int unsigned USE_N = ALPHA / NSRC,
  localparam int unsigned CW    = $clog2(ALPHA + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             swap_o,
  input logic             sel_vbe_o,
  input logic             sel_dvbe_o,
  input logic [IDX_W-1:0] dem_idx_o,
  input logic             bs_valid_o,
  input logic             done_o
);
  logic [CW-1:0] use_cnt [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) use_cnt[i] <= '0;
      else use_cnt[i] <= (bs_valid_o ? '0 : use_cnt[i])
                        + CW'(sel_dvbe_o && !swap_o && dem_idx_o == IDX_W'(i));
    end
    // R4: every source used USE_N times per long cycle
    assert_dem_balance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bs_valid_o && $past(sel_dvbe_o)) |-> use_cnt[i] == CW'(USE_N));
  end

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $onehot({sel_vbe_o, sel_dvbe_o}));
  assert_short_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_vbe_o && swap_o) |=> bs_valid_o);
  assert_long_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_dvbe_o && !swap_o) |=> sel_dvbe_o && $stable(dem_idx_o));
  assert_dem_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dem_idx_o < IDX_W'(NSRC));
  assert_swap_alt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && swap_o) |=> !swap_o);
  assert_bsv_after_swap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_valid_o |-> $past(swap_o));
  assert_done_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bs_valid_o && !busy_o && $past(busy_o));
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sel_vbe_o && !sel_dvbe_o && !swap_o);
endmodule

bind tsdm_seq tsdm_seq_chk #(.ALPHA(ALPHA), .RATIO(RATIO)) u_chk (
  .clk_i, .rst_ni, .busy_o, .swap_o, .sel_vbe_o, .sel_dvbe_o,
  .dem_idx_o, .bs_valid_o, .done_o
);

// File: tb/tsdm_seq_tb.sv
module tsdm_seq_tb;
  localparam int ALPHA = 14;
  localparam int NSRC  = 7;
  localparam int NVEC  = 6;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd4, 16'h0000}, {4'd4, 16'hFFFF}, {4'd3, 16'h0A5A},
    {4'd8, 16'hC3C3}, {4'd1, 16'h0001}, {4'd5, 16'h1234}
  };

  logic       clk_i = 0, rst_ni = 0, start_i = 0, bit_i = 0;
  logic [3:0] conv_len_i = 0;
  logic       busy_o, chop_o, swap_o, sel_vbe_o, sel_dvbe_o, bs_valid_o, bs_bit_o, done_o;
  logic [2:0] dem_idx_o;

  int checks = 0, fails = 0, cyc = 0;
  int cur_len = 1, k = 0, t = 0;
  logic [15:0] cur_pat = '0;
  logic pb = 0;

  tsdm_seq u_dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_long(input int kk);
    if (kk % cur_len == 0) return 1'b1;
    return !cur_pat[kk - 1];
  endfunction

  // monitor and bit driver
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      k = 0; t = 0; pb = 0;
    end else begin
      if (busy_o && !pb) begin
        k = 0; t = 0;
      end else if (bs_valid_o) begin
        chk(t == 2 * (exp_long(k) ? ALPHA : 1) - 1, exp_long(k) ? "R3" : "R2",
            t + 1, 2 * (exp_long(k) ? ALPHA : 1));
        chk(bs_bit_o == (cur_pat[k] ^ (k >= cur_len)), "R6", bs_bit_o,
            cur_pat[k] ^ (k >= cur_len));
        chk(done_o == (k == 2 * cur_len - 1), "R8", done_o, k == 2 * cur_len - 1);
        k++; t = 0;
      end else if (busy_o) t++;
      if (busy_o) begin
        chk(swap_o == t[0], "R5", swap_o, t[0]);
        chk(sel_dvbe_o == exp_long(k) && sel_vbe_o == !exp_long(k), "R1",
            sel_dvbe_o, exp_long(k));
        chk(dem_idx_o == (exp_long(k) ? (t / 2) % NSRC : 0), "R4", dem_idx_o,
            exp_long(k) ? (t / 2) % NSRC : 0);
        chk(chop_o == (k >= cur_len), "R7", chop_o, k >= cur_len);
      end
      pb = busy_o;
      bit_i = (k < 16) ? cur_pat[k] : 1'b0;
    end
  end

  task automatic run(input logic [3:0] len, input logic [15:0] pat, input bit poke);
    @(negedge clk_i);
    cur_len = (len == 0) ? 1 : len;
    cur_pat = pat;
    conv_len_i = len;
    @(negedge clk_i);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    conv_len_i = 4'd9;  // R9: later value must not matter
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i); #1;
      if (poke && i == 10) start_i = 1;  // R9: ignored while busy
      if (poke && i == 11) start_i = 0;
      if (done_o) break;
    end
    chk(k == 2 * cur_len, "R9", k, 2 * cur_len);
    chk(busy_o == 0, "R8", busy_o, 0);
  endtask

  initial begin
    #1;
    chk(!busy_o && !sel_vbe_o && !sel_dvbe_o && !done_o && !bs_valid_o, "R11", busy_o, 0);
    #20 rst_ni = 1;
    for (int v = 0; v < NVEC; v++) run(VEC[v][19:16], VEC[v][15:0], 1'b0);
    run(4'd3, 16'h0024, 1'b1);    // start pulse mid-run
    run(4'd0, 16'h0003, 1'b0);    // R10: zero length
    chk(k == 2, "R10", k, 2);
    // R11: asynchronous reset mid-run
    @(negedge clk_i);
    cur_len = 6; cur_pat = 16'h0F0F; conv_len_i = 6;
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    repeat (20) @(negedge clk_i);
    #1 rst_ni = 0;
    #1 chk(!busy_o && !sel_dvbe_o && !sel_vbe_o && !swap_o && dem_idx_o == 0 && !chop_o,
           "R11", busy_o, 0);
    #10 rst_ni = 1;
    run(4'd2, 16'h0006, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule